// File: doc/BRIEF.md
# Four-Phase Handshake Bus Target with Button and LED Ports

This block is the target side of a clockless request/acknowledge bus with an 8-bit address and 8-bit data. The initiator places an address, a command bit and (for writes) a data byte, then pulls its active-low request line low. The target decodes the access and then does one of two things. If the access is a read of the push-button port, it samples the button and drives it onto the read data. If the access is a write to the LED port, it loads the LED flip-flop. After a deliberate settle delay it pulls its active-low acknowledge low. The initiator then raises its request, and the target releases acknowledge and its data drive. This completes a fully interlocked four-phase cycle.

The request arrives with no relation to the block's sampling clock. It passes through a synchronizer first. A counter on the sampling clock sets the delay before acknowledge. An access to an unmapped address, or with the wrong command for a mapped address, is never acknowledged. Such an access therefore never completes.

Top module: `hsBusTarget`

## Requirements
- R1: While the asynchronous reset `rstN` is low, and after it releases: `ackN` is 1, `rdDrive` is 0, `rdData` is 0 and `led` is 0.
- R2: A request with `cmd`=0 (read) and `addr`=0x04 is acknowledged. While `ackN` is low, `rdDrive` is 1 and `rdData` carries the button state in bit 0, with bits 7..1 zero. The drive is on before `ackN` falls.
- R3: A request with `cmd`=1 (write) and `addr`=0x05 is acknowledged and loads `wdata` bit 0 into `led`. Bits 7..1 of `wdata` have no effect.
- R4: `ackN` falls exactly SYNC_STAGES+1+ACK_DELAY rising clock edges after `reqN` falls. With the defaults (2 and 4) this is 7 edges.
- R5: After `reqN` returns high, `ackN` returns high and `rdDrive` returns to 0 exactly SYNC_STAGES+1 rising edges later (3 by default). The drive stays on until that edge.
- R6: A request to any address other than 0x04/0x05, or to 0x04 with `cmd`=1, or to 0x05 with `cmd`=0, is never acknowledged. It enables no drive and leaves `led` unchanged.
- R7: The button is sampled once, when the read is accepted. `rdData` holds that value while the drive is on, whatever the button does afterwards. `rdData` is 0 whenever `rdDrive` is 0.
- R8: After a completed or abandoned access, the next well-formed access is handled normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for synchronizer, delay counter and state |
| rstN | input | 1 | Asynchronous active-low reset |
| reqN | input | 1 | Active-low request from the initiator (asynchronous) |
| cmd | input | 1 | 0 = read, 1 = write |
| addr | input | 8 | Address from the initiator |
| wdata | input | 8 | Write data from the initiator |
| button | input | 1 | Push-button level |
| ackN | output | 1 | Active-low acknowledge to the initiator |
| rdData | output | 8 | Read data, valid while rdDrive is 1 |
| rdDrive | output | 1 | Drive enable for the read data onto the shared bus |
| led | output | 1 | LED register output |

## Verification
A controller stuck in its settle state, or a counter that ends early or late, shows at the ports as `ackN` falling at the wrong edge count after `reqN`. It may also never fall, which the bench detects within its per-transfer timeout. A corrupted transaction-type flag shows as `rdDrive` on during a write, or off while a read is acknowledged, in the same cycle as the acknowledge. A wrong LED capture is visible on `led` one edge after the access is accepted. A button value that is not held appears on `rdData` within one edge of the button moving.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HOLD   = 2'd2
  } hsState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLed;
    logic loadBtn;
    logic driveEn;
  } hsStrobe_t;

endpackage

// File: rtl/hsSync.sv
module hsSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= asyncIn;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/hsCtrl.sv
module hsCtrl
  import hs_pkg::*;
#(
  parameter int ACK_DELAY   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqN,
  input  logic      hitRd,
  input  logic      hitWr,
  output hsStrobe_t strobe,
  output logic      ackN
);
  localparam int CNT_W = (ACK_DELAY > 1) ? $clog2(ACK_DELAY) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_DELAY - 1);

  logic reqSync;
  hsState_e state, nextState;
  logic [CNT_W-1:0] cnt;
  logic readTxn;
  logic ackReg;
  logic accept;

  hsSync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(~reqN),
    .syncOut(reqSync)
  );

  assign accept = (state == ST_IDLE) && reqSync && (hitRd || hitWr);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (accept) nextState = ST_SETTLE;
      ST_SETTLE: if (cnt == CNT_LAST) nextState = ST_HOLD;
      ST_HOLD:   if (!reqSync) nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      readTxn <= 1'b0;
      ackReg  <= 1'b0;
    end else begin
      state  <= nextState;
      ackReg <= (nextState == ST_HOLD);
      if (accept) begin
        cnt     <= '0;
        readTxn <= hitRd;
      end else if (state == ST_SETTLE && cnt != CNT_LAST) begin
        cnt <= cnt + 1'b1;
      end
      if (nextState == ST_IDLE) readTxn <= 1'b0;
    end
  end

  assign strobe.loadLed = accept && hitWr;
  assign strobe.loadBtn = accept && hitRd;
  assign strobe.driveEn = readTxn;
  assign ackN = ~ackReg;
endmodule

// File: rtl/hsDatapath.sv
module hsDatapath
  import hs_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  BTN_ADDR = 8'h04,
  parameter logic [7:0]  LED_ADDR = 8'h05
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              button,
  input  hsStrobe_t         strobe,
  output logic              hitRd,
  output logic              hitWr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive,
  output logic              led
);
  logic btnHold;
  logic unusedWdata;

  assign hitRd = (addr == ADDR_W'(BTN_ADDR)) && !cmd;
  assign hitWr = (addr == ADDR_W'(LED_ADDR)) && cmd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      led     <= 1'b0;
      btnHold <= 1'b0;
    end else begin
      if (strobe.loadLed) led <= wdata[0];
      if (strobe.loadBtn) btnHold <= button;
    end
  end

  assign rdDrive     = strobe.driveEn;
  assign rdData      = strobe.driveEn ? {{(DATA_W-1){1'b0}}, btnHold} : '0;
  assign unusedWdata = ^wdata[DATA_W-1:1];
endmodule

// File: rtl/hsBusTarget.sv
module hsBusTarget
  import hs_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         DATA_W      = 8,
  parameter int         ACK_DELAY   = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] BTN_ADDR    = 8'h04,
  parameter logic [7:0] LED_ADDR    = 8'h05
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqN,
  input  logic              cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              button,
  output logic              ackN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive,
  output logic              led
);
  hsStrobe_t strobe;
  logic hitRd, hitWr;

  hsCtrl #(.ACK_DELAY(ACK_DELAY), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .reqN  (reqN),
    .hitRd (hitRd),
    .hitWr (hitWr),
    .strobe(strobe),
    .ackN  (ackN)
  );

  hsDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
               .BTN_ADDR(BTN_ADDR), .LED_ADDR(LED_ADDR)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .addr   (addr),
    .wdata  (wdata),
    .button (button),
    .strobe (strobe),
    .hitRd  (hitRd),
    .hitWr  (hitWr),
    .rdData (rdData),
    .rdDrive(rdDrive),
    .led    (led)
  );
endmodule

// File: rtl/hsBusTargetChk.sv
module hsBusTargetChk #(
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 8,
  parameter logic [7:0] BTN_ADDR = 8'h04,
  parameter logic [7:0] LED_ADDR = 8'h05
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmd,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              ackN,
  input logic [DATA_W-1:0] rdData,
  input logic              rdDrive,
  input logic              led
);
  logic addrHit;
  assign addrHit = (addr == ADDR_W'(BTN_ADDR) && !cmd) ||
                   (addr == ADDR_W'(LED_ADDR) && cmd);

  // R2
  read_drive_at_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ackN) && !cmd) |-> (rdDrive && $past(rdDrive)));

  // R3
  led_loaded_at_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ackN) && cmd) |-> (led == wdata[0]));

  // R6
  ack_only_on_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackN) |-> addrHit);

  // R5
  drive_off_at_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackN) |-> !rdDrive);

  // R7
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdDrive |-> (rdData == '0));

  // R7
  held_data_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdDrive && $past(rdDrive)) |-> $stable(rdData));

  // R2
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ackN && cmd) |-> !rdDrive);
endmodule

bind hsBusTarget hsBusTargetChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BTN_ADDR(BTN_ADDR), .LED_ADDR(LED_ADDR)
) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .cmd    (cmd),
  .addr   (addr),
  .wdata  (wdata),
  .ackN   (ackN),
  .rdData (rdData),
  .rdDrive(rdDrive),
  .led    (led)
);

// File: tb/hsBusTarget_tb_top.sv
module hsBusTarget_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ACK_DELAY  = 4;
  localparam int SYNC_ST    = 2;
  localparam int ACK_LAT    = SYNC_ST + 1 + ACK_DELAY;
  localparam int REL_LAT    = SYNC_ST + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqN = 1'b1;
  logic cmd = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic button = 1'b0;
  logic ackN;
  logic [7:0] rdData;
  logic rdDrive;
  logic led;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsBusTarget #(.ACK_DELAY(ACK_DELAY), .SYNC_STAGES(SYNC_ST)) dut_i (
    .clk(clk), .rstN(rstN), .reqN(reqN), .cmd(cmd), .addr(addr),
    .wdata(wdata), .button(button), .ackN(ackN), .rdData(rdData),
    .rdDrive(rdDrive), .led(led)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // start a transfer, count edges to ack (0 if none within limit)
  task automatic startXfer(input logic [7:0] a, input logic c, input logic [7:0] d,
                           output int lat);
    @(negedge clk);
    addr = a; cmd = c; wdata = d;
    @(negedge clk);
    reqN = 1'b0;
    lat = 0;
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk); #1;
      if (!ackN) begin lat = i; break; end
    end
  endtask

  // release request, count edges to ack high
  task automatic endXfer(output int lat, output logic drvBefore);
    @(negedge clk);
    reqN = 1'b1;
    lat = 0;
    drvBefore = 1'b1;
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk); #1;
      if (ackN) begin lat = i; break; end
      if (!rdDrive) drvBefore = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    #1;
    check("R1", "ackN in reset", 32'(ackN), 1);
    check("R1", "rdDrive in reset", 32'(rdDrive), 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "ackN after reset", 32'(ackN), 1);
    check("R1", "rdData after reset", 32'(rdData), 0);
    check("R1", "led after reset", 32'(led), 0);
  endtask

  task automatic testRead(input logic btn);
    int lat, rel;
    logic drv;
    logic [7:0] held;
    button = btn;
    startXfer(8'h04, 1'b0, 8'hA5, lat);
    check("R4", "read ack latency", 32'(lat), 32'(ACK_LAT));
    check("R2", "read drive at ack", 32'(rdDrive), 1);
    check("R2", "read data", 32'(rdData), {31'b0, btn});
    held = rdData;
    @(negedge clk);
    button = ~btn;
    repeat (2) @(negedge clk);
    check("R7", "data held after button moves", 32'(rdData), 32'(held));
    endXfer(rel, drv);
    check("R5", "release latency", 32'(rel), 32'(REL_LAT));
    check("R5", "drive held until release", 32'(drv), 1);
    check("R5", "drive off after release", 32'(rdDrive), 0);
    check("R7", "data zero when idle", 32'(rdData), 0);
  endtask

  task automatic testWrite(input logic [7:0] d);
    int lat, rel;
    logic drv;
    startXfer(8'h05, 1'b1, d, lat);
    check("R4", "write ack latency", 32'(lat), 32'(ACK_LAT));
    check("R3", "no drive on write", 32'(rdDrive), 0);
    check("R3", "led value", 32'(led), 32'(d[0]));
    endXfer(rel, drv);
    check("R5", "write release latency", 32'(rel), 32'(REL_LAT));
    check("R3", "led kept after write", 32'(led), 32'(d[0]));
  endtask

  task automatic testNoAck(input logic [7:0] a, input logic c, input logic [7:0] d,
                           input string what);
    int lat;
    logic ledBefore;
    ledBefore = led;
    startXfer(a, c, d, lat);
    check("R6", {what, " not acknowledged"}, 32'(lat), 0);
    check("R6", {what, " no drive"}, 32'(rdDrive), 0);
    check("R6", {what, " led unchanged"}, 32'(led), 32'(ledBefore));
    @(negedge clk);
    reqN = 1'b1;
    repeat (6) @(negedge clk);
    check("R6", {what, " ack stays high"}, 32'(ackN), 1);
  endtask

  initial begin
    testReset();
    testRead(1'b1);
    testRead(1'b0);
    testWrite(8'hFE);
    testWrite(8'h01);
    testNoAck(8'h06, 1'b1, 8'h00, "unmapped write");
    testNoAck(8'h04, 1'b1, 8'h00, "write to button");
    testNoAck(8'h05, 1'b0, 8'h00, "read of led");
    testNoAck(8'hFF, 1'b0, 8'h00, "unmapped read");
    // R8: normal access after abandoned ones
    testRead(1'b1);
    testWrite(8'h00);
    check("R8", "led cleared after recovery", 32'(led), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule